// File: doc/BRIEF.md
# Temporal Sequence Memory Columns

This block takes, on each step, the set of active columns produced by an upstream sparse pooling stage and turns it into a pattern of active cells that carries the sequence context. Each column holds several cells. When a column becomes active, the cells that had been predicted at the step before fire and the other cells stay quiet. If no cell of that column had been predicted, every cell in the column fires, which is called a burst. The block then scores every distal segment against the new activity to find which cells are predictive for the next step. It also reports how many of the active columns burst, and software can use that count as an anomaly score.

Learning is local and online. A segment that predicted correctly gets stronger synapses onto the cells that were active at the previous step. A segment whose prediction failed gets weaker synapses. When a column bursts, a new segment is written that points at the cells that were active at the previous step. A learn-enable input freezes all storage, and activation and prediction keep running while it is low. Steps must be at least three clock cycles apart.

The default geometry is 8 columns of 4 cells. Each cell has 2 segments and each segment has 4 synapse slots. Cell number n belongs to column n / 4 and sits at position n mod 4 inside it.

Top module: `tsm_columns`

## Requirements
- R1: At the first rising edge at which `step` is high, an active column with no predictive cell bursts. All of its cells (bits 4c to 4c+3 of `cell_act` for column c) are high right after that edge.
- R2: An active column with at least one predictive cell drives exactly those predictive cells high in `cell_act` and none of its other cells.
- R3: Every cell of a column whose `col_act` bit is low is low in `cell_act` after the step.
- R4: One clock after `cell_act` updates, `cell_pred` updates. A cell is predictive when at least one of its segments has 2 or more valid synapses that have a permanence of 8 or more and point at a cell that is now active.
- R5: One clock after `cell_pred` updates, `anomaly` equals the number of columns that burst at that step.
- R6: A burst with learning enabled writes a new segment to the cell of that column that holds the fewest segments, taking the lowest position on a tie. The new segment points at up to 4 cells that were active before the step, taken in ascending index order, and each of its synapses starts at permanence 9. No segment is grown if no cell was active before the step.
- R7: A segment that was active and whose column then becomes active adds 2 to the permanence of each of its synapses onto cells active before the step. The permanence saturates at 15.
- R8: A segment that was active and whose column then stays inactive loses 1 from the permanence of each of its synapses onto cells active before the step. The permanence floors at 0, so a new segment is disconnected after two such steps.
- R9: While `learn_en` is low at a step, no permanence and no segment changes, and activation and prediction behave as in R1 to R5.
- R10: After a synchronous reset all outputs are zero and no segments exist.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| step | input | 1 | One-cycle strobe that starts a time step |
| learn_en | input | 1 | Permits changes to segment storage at a step |
| col_act | input | 8 | Active columns for this step |
| cell_act | output | 32 | Active cells, column-major |
| cell_pred | output | 32 | Cells predicted for the next step |
| anomaly | output | 4 | Number of columns that burst at the last step |

## Verification
A wrong permanence or a misplaced segment cannot be seen directly. It shows at the ports as a wrong bit of `cell_pred` two cycles after the step that uses that segment, and as a burst instead of a sparse activation at the step after that. For this reason the stimulus runs sequences that are long enough to push one permanence through the connection threshold, and the checks fix the exact step at which a prediction must appear or disappear. Growth order, the choice of target cell and the frozen storage under disabled learning are each shown by a prediction that exists only when the rule is followed.

// File: rtl/tsm_pkg.sv
package tsm_pkg;
    localparam int NCOL   = 8;
    localparam int NCELL  = 4;
    localparam int NSEG   = 2;
    localparam int NSYN   = 4;
    localparam int PERM_W = 4;

    localparam int NCELLS = NCOL * NCELL;
    localparam int IDX_W  = $clog2(NCELLS);
    localparam int CELL_W = (NCELL > 1) ? $clog2(NCELL) : 1;
    localparam int SEG_W  = (NSEG > 1) ? $clog2(NSEG) : 1;
    localparam int CNT_W  = $clog2(NSEG + 1);
    localparam int HIT_W  = $clog2(NSYN + 1);
    localparam int ANOM_W = $clog2(NCOL + 1);

    typedef logic [PERM_W-1:0] perm_t;

    typedef struct packed {
        logic             vld;
        logic [IDX_W-1:0] src;
        perm_t            perm;
    } syn_t;

    function automatic perm_t perm_add(input perm_t p, input int unsigned d);
        logic [PERM_W:0] s;
        s = {1'b0, p} + (PERM_W + 1)'(d);
        return s[PERM_W] ? '1 : s[PERM_W-1:0];
    endfunction

    function automatic perm_t perm_sub(input perm_t p, input int unsigned d);
        return (p > perm_t'(d)) ? p - perm_t'(d) : '0;
    endfunction
endpackage

// File: rtl/tsm_seg_eval.sv
module tsm_seg_eval
    import tsm_pkg::*;
#(
    parameter int CONN_PERM  = 8,
    parameter int SEG_THRESH = 2
) (
    input  syn_t [NSYN-1:0]   syns,
    input  logic [NCELLS-1:0] act,
    output logic              hit
);
    logic [HIT_W-1:0] cnt;

    always_comb begin
        cnt = '0;
        for (int y = 0; y < NSYN; y++) begin
            if (syns[y].vld && syns[y].perm >= perm_t'(CONN_PERM) && act[syns[y].src])
                cnt = cnt + 1'b1;
        end
        hit = (cnt >= HIT_W'(SEG_THRESH));
    end
endmodule

// File: rtl/tsm_grow_pick.sv
module tsm_grow_pick
    import tsm_pkg::*;
(
    input  logic [NCELLS-1:0]           prev,
    output logic [NSYN-1:0][IDX_W-1:0]  idx,
    output logic [NSYN-1:0]             vld
);
    always_comb begin
        int n;
        idx = '0;
        vld = '0;
        n   = 0;
        for (int i = 0; i < NCELLS; i++) begin
            if (prev[i] && n < NSYN) begin
                idx[n] = IDX_W'(i);
                vld[n] = 1'b1;
                n      = n + 1;
            end
        end
    end
endmodule

// File: rtl/tsm_col.sv
module tsm_col
    import tsm_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             step,
    input  logic             col_on,
    input  logic [NCELL-1:0] pred,
    output logic [NCELL-1:0] act_q,
    output logic             burst_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            act_q   <= '0;
            burst_q <= 1'b0;
        end else if (step) begin
            if (!col_on) begin
                act_q   <= '0;
                burst_q <= 1'b0;
            end else if (|pred) begin
                act_q   <= pred;
                burst_q <= 1'b0;
            end else begin
                act_q   <= '1;
                burst_q <= 1'b1;
            end
        end
    end

    // R1
    burst_all_chk: assert property (@(posedge clk) disable iff (rst)
        step && col_on && !(|pred) |=> (&act_q) && burst_q);
    // R2
    sparse_fire_chk: assert property (@(posedge clk) disable iff (rst)
        step && col_on && (|pred) |=> act_q == $past(pred) && !burst_q);
    // R3
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        step && !col_on |=> act_q == '0);
    // R1
    act_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !step |=> $stable(act_q));
endmodule

// File: rtl/tsm_columns.sv
module tsm_columns
    import tsm_pkg::*;
#(
    parameter int CONN_PERM  = 8,
    parameter int INIT_PERM  = 9,
    parameter int PERM_INC   = 2,
    parameter int PERM_DEC   = 1,
    parameter int SEG_THRESH = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              step,
    input  logic              learn_en,
    input  logic [NCOL-1:0]   col_act,
    output logic [NCELLS-1:0] cell_act,
    output logic [NCELLS-1:0] cell_pred,
    output logic [ANOM_W-1:0] anomaly
);
    syn_t [NCELLS-1:0][NSEG-1:0][NSYN-1:0] seg_mem;
    logic [NCELLS-1:0][CNT_W-1:0]          seg_cnt;
    logic [NCELLS-1:0][SEG_W-1:0]          alloc_ptr;
    logic [NCELLS-1:0][NSEG-1:0]           seg_hit;
    logic [NCELLS-1:0][NSEG-1:0]           seg_act_q;
    logic [NCELLS-1:0]                     pred_q;
    logic [NCOL-1:0]                       burst_q;
    logic [NCOL-1:0]                       burst_now;
    logic [NCOL-1:0][IDX_W-1:0]            grow_cell;
    logic [NCOL-1:0][SEG_W-1:0]            grow_slot;
    logic [NSYN-1:0][IDX_W-1:0]            pick_idx;
    logic [NSYN-1:0]                       pick_vld;
    logic                                  ph1, ph2;
    logic [ANOM_W-1:0]                     anom_q;

    // per-column activation
    for (genvar c = 0; c < NCOL; c++) begin : g_col
        tsm_col u_col (
            .clk     (clk),
            .rst     (rst),
            .step    (step),
            .col_on  (col_act[c]),
            .pred    (pred_q[c*NCELL +: NCELL]),
            .act_q   (cell_act[c*NCELL +: NCELL]),
            .burst_q (burst_q[c])
        );
        assign burst_now[c] = col_act[c] && !(|pred_q[c*NCELL +: NCELL]);
    end

    // segment scoring against the current activity
    for (genvar ci = 0; ci < NCELLS; ci++) begin : g_cell
        for (genvar s = 0; s < NSEG; s++) begin : g_seg
            tsm_seg_eval #(
                .CONN_PERM  (CONN_PERM),
                .SEG_THRESH (SEG_THRESH)
            ) u_eval (
                .syns (seg_mem[ci][s]),
                .act  (cell_act),
                .hit  (seg_hit[ci][s])
            );
        end
    end

    tsm_grow_pick u_pick (
        .prev (cell_act),
        .idx  (pick_idx),
        .vld  (pick_vld)
    );

    // growth target: fewest segments, lowest position wins a tie
    always_comb begin
        for (int c = 0; c < NCOL; c++) begin
            int best;
            best = 0;
            for (int k = 1; k < NCELL; k++) begin
                if (seg_cnt[c*NCELL + k] < seg_cnt[c*NCELL + best])
                    best = k;
            end
            grow_cell[c] = IDX_W'(c*NCELL + best);
            grow_slot[c] = alloc_ptr[c*NCELL + best];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            seg_mem   <= '0;
            seg_cnt   <= '0;
            alloc_ptr <= '0;
            seg_act_q <= '0;
            pred_q    <= '0;
            ph1       <= 1'b0;
            ph2       <= 1'b0;
            anom_q    <= '0;
        end else begin
            ph1 <= step;
            ph2 <= ph1;
            if (ph1) begin
                seg_act_q <= seg_hit;
                for (int ci = 0; ci < NCELLS; ci++)
                    pred_q[ci] <= |seg_hit[ci];
            end
            if (ph2)
                anom_q <= ANOM_W'($countones(burst_q));
            if (step && learn_en) begin
                // adapt segments that were active at the last scoring
                for (int ci = 0; ci < NCELLS; ci++) begin
                    for (int s = 0; s < NSEG; s++) begin
                        for (int y = 0; y < NSYN; y++) begin
                            if (seg_act_q[ci][s] && seg_mem[ci][s][y].vld &&
                                cell_act[seg_mem[ci][s][y].src]) begin
                                if (col_act[ci / NCELL])
                                    seg_mem[ci][s][y].perm <= perm_add(seg_mem[ci][s][y].perm, PERM_INC);
                                else
                                    seg_mem[ci][s][y].perm <= perm_sub(seg_mem[ci][s][y].perm, PERM_DEC);
                            end
                        end
                    end
                end
                // grow a segment in every bursting column
                for (int c = 0; c < NCOL; c++) begin
                    if (burst_now[c] && (|cell_act)) begin
                        for (int y = 0; y < NSYN; y++) begin
                            seg_mem[grow_cell[c]][grow_slot[c]][y] <= '{
                                vld:  pick_vld[y],
                                src:  pick_idx[y],
                                perm: pick_vld[y] ? perm_t'(INIT_PERM) : perm_t'(0)
                            };
                        end
                        if (seg_cnt[grow_cell[c]] < CNT_W'(NSEG))
                            seg_cnt[grow_cell[c]] <= seg_cnt[grow_cell[c]] + 1'b1;
                        alloc_ptr[grow_cell[c]] <= (grow_slot[c] == SEG_W'(NSEG - 1)) ?
                                                   '0 : grow_slot[c] + 1'b1;
                    end
                end
            end
        end
    end

    assign cell_pred = pred_q;
    assign anomaly   = anom_q;

    // R9
    frozen_mem_chk: assert property (@(posedge clk) disable iff (rst)
        step && !learn_en |=> $stable(seg_mem));
    // R6
    idle_mem_chk: assert property (@(posedge clk) disable iff (rst)
        !step |=> $stable(seg_mem) && $stable(seg_cnt));
    // R4
    pred_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !ph1 |=> $stable(cell_pred));
endmodule

// File: tb/tsm_columns_test.sv
module tsm_columns_test;
    import tsm_pkg::*;

    localparam int CLK_PERIOD = 10;

    typedef struct {
        logic [NCELLS-1:0] act;
        logic [NCELLS-1:0] pred;
        int                anom;
        string             tag;
    } exp_t;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              step = 1'b0;
    logic              learn_en = 1'b0;
    logic [NCOL-1:0]   col_act = '0;
    logic [NCELLS-1:0] cell_act;
    logic [NCELLS-1:0] cell_pred;
    logic [ANOM_W-1:0] anomaly;

    int   total = 0;
    int   bad = 0;
    bit   done = 1'b0;
    exp_t sb_q[$];

    tsm_columns uut (
        .clk       (clk),
        .rst       (rst),
        .step      (step),
        .learn_en  (learn_en),
        .col_act   (col_act),
        .cell_act  (cell_act),
        .cell_pred (cell_pred),
        .anomaly   (anomaly)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    task automatic check_vec(input string tag, input string what,
                             input logic [NCELLS-1:0] got, input logic [NCELLS-1:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s %s: actual=%h expected=%h", tag, what, got, exp);
        end
    endtask

    task automatic check_int(input string tag, input string what, input int got, input int exp);
        total++;
        if (got != exp) begin
            bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, got, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst  = 1'b1;
        step = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check_vec("R10 reset", "cell_act", cell_act, '0);
        check_vec("R10 reset", "cell_pred", cell_pred, '0);
        check_int("R10 reset", "anomaly", int'(anomaly), 0);
    endtask

    // driver: pushes the expectation, then strobes one step
    task automatic do_step(input logic [NCOL-1:0] cols, input logic learn,
                           input logic [NCELLS-1:0] e_act, input logic [NCELLS-1:0] e_pred,
                           input int e_anom, input string tag);
        exp_t item;
        item.act  = e_act;
        item.pred = e_pred;
        item.anom = e_anom;
        item.tag  = tag;
        sb_q.push_back(item);
        @(negedge clk);
        col_act  = cols;
        learn_en = learn;
        step     = 1'b1;
        @(negedge clk);
        step = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    // monitor: results settle two edges after the step edge
    initial begin
        forever begin
            @(posedge clk);
            if (step === 1'b1 && rst === 1'b0) begin
                exp_t item;
                repeat (2) @(posedge clk);
                @(negedge clk);
                if (sb_q.size() == 0) begin
                    total++;
                    bad++;
                    $display("FAIL scoreboard: result without expectation");
                end else begin
                    item = sb_q.pop_front();
                    check_vec(item.tag, "cell_act", cell_act, item.act);
                    check_vec(item.tag, "cell_pred", cell_pred, item.pred);
                    check_int(item.tag, "anomaly", int'(anomaly), item.anom);
                end
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        do_reset();
        // several bursts at once; then ascending growth onto cells 0..3
        do_step(8'b0010_0011, 1'b1, 32'h00F0_00FF, 32'h0, 3, "R1 R3 R5 multi-burst");
        do_step(8'b0000_0001, 1'b1, 32'h0000_000F, 32'h1, 1, "R6 R4 ascending growth");
        do_step(8'b0000_0001, 1'b1, 32'h0000_0001, 32'h0, 0, "R2 predicted cell alone");
        do_step(8'b0000_0000, 1'b1, 32'h0, 32'h0, 0, "R3 no columns");

        do_reset();
        do_step(8'h01, 1'b1, 32'h0000_000F, 32'h0, 1, "R1 first burst");
        do_step(8'h02, 1'b1, 32'h0000_00F0, 32'h0, 1, "R6 grow on cell4");
        do_step(8'h01, 1'b1, 32'h0000_000F, 32'h10, 1, "R4 cell4 predicted");
        do_step(8'h02, 1'b1, 32'h0000_0010, 32'h0, 0, "R2 R7 correct prediction");
        do_step(8'h01, 1'b1, 32'h0000_000F, 32'h10, 1, "R6 fewest-segment cell");
        do_step(8'h04, 1'b1, 32'h0000_0F00, 32'h0, 1, "R8 first miss");
        do_step(8'h01, 1'b1, 32'h0000_000F, 32'h110, 1, "R7 R8 still connected");
        do_step(8'h08, 1'b1, 32'h0000_F000, 32'h0, 1, "R8 second miss");
        do_step(8'h01, 1'b1, 32'h0000_000F, 32'h1110, 1, "R8 perm 8 connected");
        do_step(8'h20, 1'b1, 32'h00F0_0000, 32'h0, 1, "R8 third miss");
        do_step(8'h01, 1'b1, 32'h0000_000F, 32'h0010_1010, 1, "R7 R8 reinforced survives");
        do_step(8'h21, 1'b1, 32'h0010_000F, 32'h0010_0002, 1, "R2 R5 R6 mixed step");

        do_reset();
        do_step(8'h01, 1'b1, 32'h0000_000F, 32'h0, 1, "R9 setup");
        do_step(8'h02, 1'b1, 32'h0000_00F0, 32'h0, 1, "R9 setup grow");
        do_step(8'h01, 1'b1, 32'h0000_000F, 32'h10, 1, "R9 setup predict");
        do_step(8'h04, 1'b0, 32'h0000_0F00, 32'h0, 1, "R9 miss without learning");
        do_step(8'h01, 1'b0, 32'h0000_000F, 32'h10, 1, "R9 no growth no decay");
        do_step(8'h08, 1'b0, 32'h0000_F000, 32'h0, 1, "R9 second miss frozen");
        do_step(8'h01, 1'b0, 32'h0000_000F, 32'h10, 1, "R9 permanence kept");
        do_step(8'h02, 1'b0, 32'h0000_0010, 32'h0, 0, "R9 R2 activation runs");

        repeat (6) @(negedge clk);
        if (sb_q.size() != 0) begin
            total++;
            bad++;
            $display("FAIL scoreboard: %0d expectations left, expected 0", sb_q.size());
        end
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule